// File: doc/BRIEF.md
# Cache Slot Lock Stack Controller

This block decides which slots of a small instruction-fetch cache are protected from replacement. Protection is managed as a stack that grows downward. A slot pointer starts at the top slot. Each locking fetch places a code segment into the slot the pointer names and then moves the pointer down by one. An unlock command moves the pointer up by one again. Every slot above the pointer counts as locked. The one exception is a pointer of zero, which releases the whole cache.

Software works the block through one byte-wide control register:
- bit 7 enables locking on code reads;
- bit 6 is an unlock strobe that clears itself;
- bits 4:0 are a read-only view of the pointer.

A code-read event, carrying a byte address, starts a locking fill while locking is enabled. The block then raises a one-cycle request to the cache fill logic. The request names the target slot and the aligned segment address. The lock mask goes to the replacement logic, which must keep normal fills out of any slot marked in it.

Top module: `cache_lock_stack`

## Requirements
- R1: After reset the register reads 0x1F (locking disabled, pointer 31), the lock mask is all zero and no fill request is raised.
- R2: A register write stores bit 7 as the lock-enable flag, and bit 7 of the read value returns it.
- R3: With lock enable set, a code read with no unlock in that cycle raises a fill request on the next cycle. The request carries the pointer value from before the event and the event address with its two low bits cleared. The pointer then decreases by one.
- R4: With lock enable clear, a code read raises no fill request and leaves the pointer unchanged.
- R5: Writing 1 to bit 6 increases the pointer by one. Bit 6 always reads back as 0.
- R6: Lock mask bit i is 1 exactly when i is greater than the pointer and the pointer is not zero.
- R7: When the pointer is 0, the lock mask is all zero, whatever locking fetches came before.
- R8: Writes to bits 5:0 other than bit 6 do not change the pointer, and bit 5 always reads 0.
- R9: An unlock write and a code read in the same cycle produce the unlock alone. The pointer increases by one and no fill request is raised.
- R10: A fill request lasts one cycle per locking event. It is low in any cycle that follows a cycle with no locking event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read value |
| code_rd | input | 1 | Code-read event, one cycle per read |
| code_addr | input | ADDR_W (16) | Byte address of the code read |
| lock_mask | output | SLOTS (32) | Per-slot lock flags |
| fill_req | output | 1 | One-cycle fill request for a locking fetch |
| fill_slot | output | 5 | Target slot of the fill request |
| fill_addr | output | ADDR_W (16) | Segment-aligned address of the fill request |

## Verification
A write or code read sampled at clock edge k changes the pointer and the read value at that same edge. The lock mask follows the pointer with no added delay. The fill request, with its slot and address, is registered and so is visible only in the cycle after edge k. The bench drives each stimulus on a falling edge and checks the read value, the mask and the fill fields on the next falling edge, so exactly one rising edge lies between stimulus and check. A request that is still high one cycle later is caught by the idle vector that follows it.

// File: rtl/lockstk_pkg.sv
package lockstk_pkg;
  localparam int CTRL_W   = 8;
  localparam int LOCK_BIT = 7;
  localparam int POP_BIT  = 6;
  localparam int RSV_BIT  = 5;
endpackage

// File: rtl/lockstk_ptr.sv
module lockstk_ptr #(
  parameter int SLOTS = 32,
  localparam int PTR_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  input  logic             code_rd,
  output logic             lock_en,
  output logic [PTR_W-1:0] ptr,
  output logic             push
);
  import lockstk_pkg::*;

  logic pop;
  assign pop  = reg_wr && reg_wdata[POP_BIT];
  assign push = code_rd && lock_en && !pop;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_en <= 1'b0;
      ptr     <= PTR_W'(SLOTS - 1);
    end else begin
      if (reg_wr) lock_en <= reg_wdata[LOCK_BIT];
      if (pop)
        ptr <= ptr + 1'b1;
      else if (push)
        ptr <= ptr - 1'b1;
    end
  end

  // R3
  push_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (code_rd && lock_en && !(reg_wr && reg_wdata[POP_BIT])) |=> (ptr == PTR_W'($past(ptr) - 1'b1)));
  // R5
  pop_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_wdata[POP_BIT]) |=> (ptr == PTR_W'($past(ptr) + 1'b1)));
  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!(code_rd && lock_en) && !(reg_wr && reg_wdata[POP_BIT])) |=> $stable(ptr));
endmodule

// File: rtl/lockstk_mask.sv
module lockstk_mask #(
  parameter int SLOTS = 32,
  localparam int PTR_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PTR_W-1:0] ptr,
  output logic [SLOTS-1:0] mask
);
  logic any;
  assign any = (ptr != '0);

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    assign mask[i] = any && (i > int'(ptr));
  end

  // R7
  zero_free_chk: assert property (@(posedge clk) disable iff (rst)
    (ptr == '0) |-> (mask == '0));
  // R6
  mask_count_chk: assert property (@(posedge clk) disable iff (rst)
    (ptr != '0) |-> ($countones(mask) == (SLOTS - 1 - int'(ptr))));
endmodule

// File: rtl/lockstk_fill.sv
module lockstk_fill #(
  parameter int SLOTS     = 32,
  parameter int ADDR_W    = 16,
  parameter int SEG_BYTES = 4,
  localparam int PTR_W    = $clog2(SLOTS),
  localparam int SEG_LSB  = $clog2(SEG_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [PTR_W-1:0]  slot_in,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              fill_req,
  output logic [PTR_W-1:0]  fill_slot,
  output logic [ADDR_W-1:0] fill_addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      fill_req  <= 1'b0;
      fill_slot <= '0;
      fill_addr <= '0;
    end else begin
      fill_req <= push;
      if (push) begin
        fill_slot <= slot_in;
        fill_addr <= {addr_in[ADDR_W-1:SEG_LSB], SEG_LSB'(0)};
      end
    end
  end

  // R10
  fill_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !push |=> !fill_req);
  // R3
  fill_align_chk: assert property (@(posedge clk) disable iff (rst)
    fill_req |-> (fill_addr[SEG_LSB-1:0] == '0));
endmodule

// File: rtl/cache_lock_stack.sv
module cache_lock_stack #(
  parameter int SLOTS     = 32,
  parameter int ADDR_W    = 16,
  parameter int SEG_BYTES = 4,
  localparam int PTR_W    = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              code_rd,
  input  logic [ADDR_W-1:0] code_addr,
  output logic [SLOTS-1:0]  lock_mask,
  output logic              fill_req,
  output logic [PTR_W-1:0]  fill_slot,
  output logic [ADDR_W-1:0] fill_addr
);
  import lockstk_pkg::*;

  logic             lock_en;
  logic [PTR_W-1:0] ptr;
  logic             push;

  lockstk_ptr #(.SLOTS(SLOTS)) u_ptr (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .code_rd(code_rd), .lock_en(lock_en), .ptr(ptr), .push(push)
  );

  lockstk_mask #(.SLOTS(SLOTS)) u_mask (
    .clk(clk), .rst(rst), .ptr(ptr), .mask(lock_mask)
  );

  lockstk_fill #(.SLOTS(SLOTS), .ADDR_W(ADDR_W), .SEG_BYTES(SEG_BYTES)) u_fill (
    .clk(clk), .rst(rst), .push(push), .slot_in(ptr), .addr_in(code_addr),
    .fill_req(fill_req), .fill_slot(fill_slot), .fill_addr(fill_addr)
  );

  always_comb begin
    reg_rdata                = '0;
    reg_rdata[LOCK_BIT]      = lock_en;
    reg_rdata[PTR_W-1:0]     = ptr;
  end

  // R8
  rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata[RSV_BIT] == 1'b0) && (reg_rdata[POP_BIT] == 1'b0));
  // R9
  pop_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_wdata[POP_BIT]) |=> !fill_req);
endmodule

// File: tb/cache_lock_stack_bench.sv
module cache_lock_stack_bench;
  localparam int SLOTS  = 32;
  localparam int ADDR_W = 16;

  typedef struct packed {
    logic        wr;
    logic [7:0]  wdata;
    logic        rd;
    logic [15:0] addr;
    logic [7:0]  e_rdata;
    logic        e_fill;
    logic [4:0]  e_slot;
    logic [15:0] e_faddr;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 8'h00, 1'b1, 16'h1234, 8'h1F, 1'b0, 5'd0,  16'h0000}, // R4
    '{1'b1, 8'h80, 1'b0, 16'h0000, 8'h9F, 1'b0, 5'd0,  16'h0000}, // R2
    '{1'b0, 8'h00, 1'b1, 16'h1237, 8'h9E, 1'b1, 5'd31, 16'h1234}, // R3
    '{1'b0, 8'h00, 1'b1, 16'h2001, 8'h9D, 1'b1, 5'd30, 16'h2000}, // R3
    '{1'b0, 8'h00, 1'b0, 16'h0000, 8'h9D, 1'b0, 5'd0,  16'h0000}, // R10
    '{1'b1, 8'hDF, 1'b0, 16'h0000, 8'h9E, 1'b0, 5'd0,  16'h0000}, // R5 R8
    '{1'b1, 8'hC0, 1'b1, 16'h3333, 8'h9F, 1'b0, 5'd0,  16'h0000}, // R9
    '{1'b1, 8'h3F, 1'b0, 16'h0000, 8'h1F, 1'b0, 5'd0,  16'h0000}, // R8
    '{1'b0, 8'h00, 1'b1, 16'h4444, 8'h1F, 1'b0, 5'd0,  16'h0000}  // R4
  };

  logic              clk = 0;
  logic              rst = 1;
  logic              reg_wr = 0;
  logic [7:0]        reg_wdata = 0;
  logic [7:0]        reg_rdata;
  logic              code_rd = 0;
  logic [ADDR_W-1:0] code_addr = 0;
  logic [SLOTS-1:0]  lock_mask;
  logic              fill_req;
  logic [4:0]        fill_slot;
  logic [ADDR_W-1:0] fill_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  cache_lock_stack u_cache_lock_stack (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .code_rd(code_rd), .code_addr(code_addr),
    .lock_mask(lock_mask), .fill_req(fill_req), .fill_slot(fill_slot),
    .fill_addr(fill_addr)
  );

  function automatic logic [SLOTS-1:0] exp_mask(input logic [4:0] p);
    logic [SLOTS-1:0] m = '0;
    for (int i = 0; i < SLOTS; i++) m[i] = (p != 0) && (i > int'(p));
    return m;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic wr, input logic [7:0] wd, input logic rd, input logic [15:0] a);
    reg_wr = wr; reg_wdata = wd; code_rd = rd; code_addr = a;
    @(negedge clk);
    reg_wr = 0; reg_wdata = 0; code_rd = 0; code_addr = 0;
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 rdata", 64'(reg_rdata), 64'h1F);
    chk("R1 mask",  64'(lock_mask), 64'h0);
    chk("R1 fill",  64'(fill_req),  64'h0);

    for (int v = 0; v < NV; v++) begin
      drive(TBL[v].wr, TBL[v].wdata, TBL[v].rd, TBL[v].addr);
      chk("R2/R5/R8 rdata", 64'(reg_rdata), 64'(TBL[v].e_rdata));
      chk("R10/R4/R9 fill_req", 64'(fill_req), 64'(TBL[v].e_fill));
      if (TBL[v].e_fill) begin
        chk("R3 fill_slot", 64'(fill_slot), 64'(TBL[v].e_slot));
        chk("R3 fill_addr", 64'(fill_addr), 64'(TBL[v].e_faddr));
      end
      chk("R6 mask", 64'(lock_mask), 64'(exp_mask(TBL[v].e_rdata[4:0])));
    end

    // R6: lock down to pointer 1 with back-to-back pushes
    drive(1'b1, 8'h80, 1'b0, 16'h0);
    for (int k = 0; k < 30; k++) drive(1'b0, 8'h00, 1'b1, 16'(k * 4 + 3));
    chk("R3 fill_slot last", 64'(fill_slot), 64'd2);
    chk("R6 rdata ptr1", 64'(reg_rdata), 64'h81);
    chk("R6 mask ptr1", 64'(lock_mask), 64'hFFFF_FFFC);
    // R7: one more push reaches zero, whole cache free
    drive(1'b0, 8'h00, 1'b1, 16'hABCD);
    chk("R7 rdata ptr0", 64'(reg_rdata), 64'h80);
    chk("R7 mask", 64'(lock_mask), 64'h0);
    chk("R3 slot1", 64'(fill_slot), 64'd1);
    drive(1'b0, 8'h00, 1'b0, 16'h0);
    chk("R10 idle", 64'(fill_req), 64'h0);
    // R5: unlock back to pointer 1
    drive(1'b1, 8'hC0, 1'b0, 16'h0);
    chk("R5 rdata", 64'(reg_rdata), 64'h81);
    chk("R5 mask", 64'(lock_mask), 64'hFFFF_FFFC);
    // R1: reset again mid-run
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk("R1 rdata again", 64'(reg_rdata), 64'h1F);
    chk("R1 mask again", 64'(lock_mask), 64'h0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule